// File: doc/BRIEF.md
# Staged Loadable Shift Register

This block pairs a parallel holding register with a shift register. Both share one bidirectional port. When the port is released, a rising edge of the storage clock captures the pin levels into the holding register. While the load strobe is low and the shift clock is low, the shift register copies the holding register. With load high, a rising shift-clock edge moves the shift register up by one place and takes a new bit from one of two serial inputs. When the port is enabled it drives the shift-register contents. A separate serial output always shows the top bit.

Both device clocks are ordinary inputs. One fast system clock samples them and every other input through a common synchronizer chain, so control and data stay aligned with the clock they qualify. A sampled low-to-high transition counts as the edge. The clear input is asynchronous on the shift register. Its synchronized copy also blocks any edge that was still in flight when the clear was released. An effect becomes visible at the third system-clock edge after the input was first sampled.

Top module: `staged_shift_register`

## Requirements
- R1: With `oe_n` high, a rising edge of `st_clk` stores the levels on `pio` into the holding register.
- R2: While `load_n` is low and `sh_clk` is low, the shift register keeps copying the holding register.
- R3: A rising `sh_clk` edge with `load_n` high and `sh_hold` low shifts: bit 0 takes the chosen serial input and bit i takes the old bit i-1.
- R4: `sel` low chooses `ser0` and `sel` high chooses `ser1`. The select may change between shifts.
- R5: A rising `sh_clk` edge with `sh_hold` high leaves the shift register unchanged.
- R6: While `sh_clk` is high, a low `load_n` has no effect. If `sh_clk` then falls with `load_n` still low, the load takes place.
- R7: A low `clear_n` zeroes the shift register and `serial_o` at once and overrides a shift. A shift-clock edge seen during the clear is not acted on after release.
- R8: `serial_o` always equals shift-register bit 7 and stays driven while the port is released.
- R9: `oe_n` high puts all 8 `pio` bits in high impedance. Shifting continues unaffected, and `oe_n` low drives the shift register onto `pio`.
- R10: With `load_n` and `sh_clk` both low, a storage-clock edge carries the new pin data through the holding register into the shift register.
- R11: `conflict_o` is high exactly while `clear_n` and `load_n` are both low, which is the illegal combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| st_clk | input | 1 | Storage clock; a rising edge captures the port pins |
| sh_clk | input | 1 | Shift clock; a rising edge shifts, a high level blocks loading |
| sh_hold | input | 1 | High makes a shift-clock edge hold |
| load_n | input | 1 | Active-low level load from the holding register |
| clear_n | input | 1 | Active-low asynchronous clear of the shift register |
| sel | input | 1 | Serial source select: 0 = ser0, 1 = ser1 |
| ser0 | input | 1 | Serial data input 0 |
| ser1 | input | 1 | Serial data input 1 |
| oe_n | input | 1 | Active-low port output enable |
| pio | inout | 8 | Shared port: shift-register output or holding-register input |
| serial_o | output | 1 | Shift-register bit 7, always driven |
| conflict_o | output | 1 | Illegal clear-with-load indication |

## Verification
A storage-clock edge and the level load can act in the same system cycle when `load_n` and `sh_clk` are both low. The bench sets up that pass-through case with a shift-register value that differs from the new pin pattern, and expects the new pattern to reach the port. The clear and a shift edge also meet: the bench raises `sh_clk` together with `clear_n` low. It then expects zeros at once and still zeros after release, with no late shift.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
    // Field positions inside the sampled input vector
    localparam int F_STCLK = 0;
    localparam int F_SHCLK = 1;
    localparam int F_HOLD  = 2;
    localparam int F_LOADN = 3;
    localparam int F_SEL   = 4;
    localparam int F_SER0  = 5;
    localparam int F_SER1  = 6;
    localparam int F_CLRN  = 7;
    localparam int F_PINS  = 8;
    localparam int N_EDGE  = 2;   // the two device clocks sit in the low bits

    typedef enum logic [1:0] {
        SR_KEEP  = 2'd0,
        SR_LOAD  = 2'd1,
        SR_SHIFT = 2'd2
    } sr_op_e;

    function automatic int smp_width(int w);
        return F_PINS + w;
    endfunction
endpackage

// File: rtl/ssr_sync.sv
`timescale 1ns/1ps
module ssr_sync #(
    parameter int N      = 16,
    parameter int STAGES = 2,
    parameter int EDGE_N = 2
) (
    input  logic              clk,
    input  logic [N-1:0]      raw_i,
    output logic [N-1:0]      sync_o,
    output logic [EDGE_N-1:0] prev_o
);
    logic [STAGES-1:0][N-1:0] chain_d, chain_q;
    logic [EDGE_N-1:0]        prev_d, prev_q;

    always_comb begin
        chain_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        prev_d = chain_q[STAGES-1][EDGE_N-1:0];
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
        prev_q  <= prev_d;
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/ssr_core.sv
`timescale 1ns/1ps
module ssr_core
    import ssr_pkg::*;
#(
    parameter int W  = 8,
    localparam int SW = F_PINS + W
) (
    input  logic                clk,
    input  logic                clear_n,
    input  logic [SW-1:0]       smp_i,
    input  logic [N_EDGE-1:0]   prev_i,
    output logic [W-1:0]        shreg_o
);
    logic         st_rise, sh_rise, sh_lvl, hold, load_n, sel, clr_ok, ser_bit;
    logic [W-1:0] pins;
    logic [W-1:0] store_d, store_q, shreg_d, shreg_q;
    sr_op_e       op;

    always_comb begin
        st_rise = smp_i[F_STCLK] & ~prev_i[F_STCLK];
        sh_rise = smp_i[F_SHCLK] & ~prev_i[F_SHCLK];
        sh_lvl  = smp_i[F_SHCLK];
        hold    = smp_i[F_HOLD];
        load_n  = smp_i[F_LOADN];
        sel     = smp_i[F_SEL];
        clr_ok  = smp_i[F_CLRN];
        pins    = smp_i[F_PINS +: W];
        ser_bit = sel ? smp_i[F_SER1] : smp_i[F_SER0];

        // Holding register: edge capture from the port
        store_d = st_rise ? pins : store_q;

        // Level load only with the shift clock low; edge shift only with load high
        op = SR_KEEP;
        if (clr_ok) begin
            if (!load_n && !sh_lvl)
                op = SR_LOAD;
            else if (sh_rise && load_n && !hold)
                op = SR_SHIFT;
        end

        case (op)
            SR_LOAD:  shreg_d = store_q;
            SR_SHIFT: shreg_d = {shreg_q[W-2:0], ser_bit};
            default:  shreg_d = shreg_q;
        endcase
    end

    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) shreg_q <= '0;
        else          shreg_q <= shreg_d;
    end

    assign shreg_o = shreg_q;

    AST_STORE_CAPTURE: assert property (@(posedge clk) disable iff (!clear_n)
        st_rise |=> store_q == $past(pins)); // R1
    AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!clear_n)
        (clr_ok && !load_n && !sh_lvl) |=> shreg_q == $past(store_q)); // R2
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!clear_n)
        (clr_ok && sh_rise && load_n && !hold) |=> shreg_q[W-1:1] == $past(shreg_q[W-2:0])); // R3
    AST_HOLD_EDGE: assert property (@(posedge clk) disable iff (!clear_n)
        (sh_rise && hold) |=> $stable(shreg_q)); // R5
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!clear_n)
        (sh_lvl && !sh_rise) |=> $stable(shreg_q)); // R6
endmodule

// File: rtl/staged_shift_register.sv
`timescale 1ns/1ps
module staged_shift_register
    import ssr_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         st_clk,
    input  logic         sh_clk,
    input  logic         sh_hold,
    input  logic         load_n,
    input  logic         clear_n,
    input  logic         sel,
    input  logic         ser0,
    input  logic         ser1,
    input  logic         oe_n,
    inout  wire  [W-1:0] pio,
    output logic         serial_o,
    output logic         conflict_o
);
    localparam int SW = smp_width(W);

    logic [SW-1:0]     raw, smp;
    logic [N_EDGE-1:0] prev;
    logic [W-1:0]      shreg;

    always_comb begin
        raw                = '0;
        raw[F_STCLK]       = st_clk;
        raw[F_SHCLK]       = sh_clk;
        raw[F_HOLD]        = sh_hold;
        raw[F_LOADN]       = load_n;
        raw[F_SEL]         = sel;
        raw[F_SER0]        = ser0;
        raw[F_SER1]        = ser1;
        raw[F_CLRN]        = clear_n;
        raw[F_PINS +: W]   = pio;
    end

    ssr_sync #(.N(SW), .STAGES(STAGES), .EDGE_N(N_EDGE)) sync_i (
        .clk    (clk),
        .raw_i  (raw),
        .sync_o (smp),
        .prev_o (prev)
    );

    ssr_core #(.W(W)) core_i (
        .clk     (clk),
        .clear_n (clear_n),
        .smp_i   (smp),
        .prev_i  (prev),
        .shreg_o (shreg)
    );

    for (genvar b = 0; b < W; b++) begin : g_pad
        assign pio[b] = oe_n ? 1'bz : shreg[b];
    end

    assign serial_o   = shreg[W-1];
    assign conflict_o = ~clear_n & ~load_n;
endmodule

// File: tb/staged_shift_register_tb_top.sv
`timescale 1ns/1ps
module staged_shift_register_tb_top;
    logic clk = 1'b0;
    logic st_clk = 0, sh_clk = 0, sh_hold = 0, load_n = 1, clear_n = 0;
    logic sel = 0, ser0 = 0, ser1 = 0, oe_n = 1;
    logic drive_en = 0;
    logic [7:0] tb_pins = '0;
    wire  [7:0] pio;
    logic serial_o, conflict_o;

    int checks = 0, errors = 0;
    logic [7:0] exp_store, exp_sh;

    assign pio = drive_en ? tb_pins : 8'bz;

    always #5 clk = ~clk;

    staged_shift_register dut_i (
        .clk(clk), .st_clk(st_clk), .sh_clk(sh_clk), .sh_hold(sh_hold),
        .load_n(load_n), .clear_n(clear_n), .sel(sel), .ser0(ser0), .ser1(ser1),
        .oe_n(oe_n), .pio(pio), .serial_o(serial_o), .conflict_o(conflict_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_sh();
        sh_clk = 1; settle();
        sh_clk = 0; settle();
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        check("R7 serial after clear", {7'd0, serial_o}, 8'd0);
        oe_n = 0; #1;
        check("R7 port after clear", pio, 8'h00);
        clear_n = 1; settle();
        exp_sh = 8'h00;
    endtask

    task automatic t_store_load(input logic [7:0] val);
        oe_n = 1; #1; drive_en = 1; tb_pins = val; settle();
        st_clk = 1; settle(); st_clk = 0; settle();
        drive_en = 0; exp_store = val;
        load_n = 0; settle(); load_n = 1; settle();
        oe_n = 0; #1;
        exp_sh = exp_store;
        check("R1 R2 store then load", pio, exp_sh);
    endtask

    task automatic t_shift(input int n, input logic [7:0] pat0, input logic [7:0] pat1, input bit alt_sel);
        for (int i = 0; i < n; i++) begin
            sel  = alt_sel ? i[0] : 1'b0;
            ser0 = pat0[i];
            ser1 = pat1[i];
            pulse_sh();
            exp_sh = {exp_sh[6:0], sel ? ser1 : ser0};
            check(alt_sel ? "R4 select shift" : "R3 shift", pio, exp_sh);
            check("R8 serial bit7", {7'd0, serial_o}, {7'd0, exp_sh[7]});
        end
    endtask

    task automatic t_hold();
        sh_hold = 1; ser0 = ~exp_sh[0]; pulse_sh(); sh_hold = 0;
        check("R5 hold edge", pio, exp_sh);
    endtask

    task automatic t_lockout();
        ser0 = 1; sel = 0;
        sh_clk = 1; settle();
        exp_sh = {exp_sh[6:0], 1'b1};
        load_n = 0; settle();
        check("R6 load locked out", pio, exp_sh);
        sh_clk = 0; settle();
        exp_sh = exp_store;
        check("R6 load after fall", pio, exp_sh);
        load_n = 1; settle();
    endtask

    task automatic t_oe();
        oe_n = 1; #1;
        check("R9 port released", pio, 8'bzzzzzzzz);
        sel = 1; ser1 = 1;
        for (int i = 0; i < 2; i++) begin
            pulse_sh();
            exp_sh = {exp_sh[6:0], 1'b1};
            check("R8 serial while released", {7'd0, serial_o}, {7'd0, exp_sh[7]});
        end
        oe_n = 0; #1;
        check("R9 shifting continued", pio, exp_sh);
    endtask

    task automatic t_pass(input logic [7:0] val);
        oe_n = 1; #1; drive_en = 1; tb_pins = val;
        load_n = 0; settle();
        st_clk = 1; settle(); st_clk = 0;
        drive_en = 0; load_n = 1; settle();
        exp_store = val; exp_sh = val;
        oe_n = 0; #1;
        check("R10 pass-through", pio, exp_sh);
    endtask

    task automatic t_clear_override();
        load_n = 1; sel = 0; ser0 = 1;
        sh_clk = 1; clear_n = 0; #1;
        check("R7 serial cleared at once", {7'd0, serial_o}, 8'd0);
        settle();
        check("R7 clear over shift", pio, 8'h00);
        clear_n = 1; settle();
        sh_clk = 0; settle();
        exp_sh = 8'h00;
        check("R7 no late shift", pio, exp_sh);
    endtask

    task automatic t_conflict();
        clear_n = 0; #1;
        check("R11 clear alone", {7'd0, conflict_o}, 8'd0);
        load_n = 0; #1;
        check("R11 clear with load", {7'd0, conflict_o}, 8'd1);
        load_n = 1; #1;
        check("R11 load released", {7'd0, conflict_o}, 8'd0);
        clear_n = 1; settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_store_load(8'hA5);
        t_shift(8, 8'b1100_1010, 8'b0000_0000, 1'b0);
        t_store_load(8'h3C);
        t_shift(8, 8'b0000_0000, 8'b1111_1111, 1'b1);
        t_hold();
        t_lockout();
        t_oe();
        t_pass(8'h96);
        t_clear_override();
        t_conflict();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule